// File: doc/BRIEF.md
# Command-Driven SPI Master with Write-Only Lead-In

This block is an SPI master that runs one complete message for each start command. Software writes the bytes to send into an on-chip transmit buffer. It sets a byte count and a message type in a transfer-control register. It then writes a command word that carries a start code, a lead-in count and a device number. The block asserts one active-low chip select and clocks out the optional write-only lead-in bytes. It then runs the main phase as full duplex, half-duplex read or half-duplex write, and drops the select after the last bit.

Received main-phase bytes are stored in a receive buffer, and a tail register reports how many were stored. On completion a sticky done flag is set, and an interrupt line follows it when the mask bit is set. Because the select cannot be held between commands, a command-then-read exchange must be packed into one start: the lead-in carries the command bytes and a half-duplex read follows. SCLK comes from the system clock at one of seven power-of-two rates. Clock polarity and phase are both selectable, and bits travel MSB first.

Top module: `spi_cmd_master`

## Requirements
- R1: After reset every chip select is high and SCLK, MOSI and irq are low. The status register (address 2) and the receive-tail register (address 5) read 0.
- R2: A write to address 1 with bits 1:0 equal to 3 starts a command. Bits 7:4 give the lead-in count (0 to 15) and bits 9:8 give the device number. The busy flag (status bit 1) is set from the next cycle until the command ends.
- R3: When the lead-in count L is non-zero, transmit buffer bytes 0 to L-1 go out first. They are written only: no byte is captured while they are sent.
- R4: The main phase sends the count taken from address 0, bits 6:0. That count excludes the lead-in bytes. Its transmit bytes are buffer positions L onward, and buffer byte i is written at address 0x80+i. The message type sits in bits 9:8: 0 full duplex, 1 half-duplex read with MOSI held low, 2 or 3 half-duplex write.
- R5: In full-duplex and read types, main-phase byte k is stored at receive position k, read at address 0x80+k. The tail register then equals the main count. A write type stores nothing and leaves the tail at 0.
- R6: Only the selected device's line is low, and it stays low for the whole command, lead-in included. All lines are high whenever the block is idle.
- R7: Address 4 bits 2:0 select a rate r. Each SCLK half-period lasts 2^r system cycles, and r = 7 behaves as r = 6. The first half-period begins in the cycle after the start write, and each byte spans 16 half-periods.
- R8: Done (status bit 0) is set on the edge that ends the last bit. It stays set until a status write whose low byte is 0xFF; any other status write leaves it set. irq equals done AND the mask bit (address 3, bit 0).
- R9: Address 4 bit 3 is polarity and bit 4 is phase. Idle SCLK equals polarity. With phase 0, MISO is sampled on the first edge of each bit and MOSI changes on the second; with phase 1 it is the reverse. Bits are MSB first.
- R10: A start write while busy is ignored. The running command continues unchanged.
- R11: A start with zero count and zero lead-in sets done on the same edge, never asserts a select and never sets busy.
- R12: A write to address 6 changes only the rate bits of the clock configuration. Polarity and phase stay as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register or buffer write strobe |
| bus_addr | input | 8 | Register index or buffer address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from bus_addr |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 4 | Active-low chip selects, one per device |
| irq | output | 1 | Done interrupt |

## Verification
The assertions take two things for granted. Software changes the clock configuration and the transfer control only while the block is idle. It never writes the clear pattern on the edge where a command ends. The stimulus keeps within these limits: it issues every configuration write and every clear between commands, and waits on its own model's idle flag before moving on. The assertions also assume that the lead-in plus the main count fits in the buffer. Every command the bench issues stays well under 64 bytes.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
   typedef enum logic [1:0] {
      XT_FULL  = 2'd0,
      XT_READ  = 2'd1,
      XT_WRITE = 2'd2,
      XT_WALT  = 2'd3
   } xfer_type_e;

   localparam logic [2:0] A_XFER = 3'd0;
   localparam logic [2:0] A_CMD  = 3'd1;
   localparam logic [2:0] A_STAT = 3'd2;
   localparam logic [2:0] A_MASK = 3'd3;
   localparam logic [2:0] A_CLK  = 3'd4;
   localparam logic [2:0] A_TAIL = 3'd5;
   localparam logic [2:0] A_RATE = 3'd6;

   localparam logic [1:0] START_CODE = 2'b11;
   localparam logic [7:0] CLEAR_ALL  = 8'hFF;
   localparam int         PRE_W      = 4;
endpackage

// File: rtl/spi_half_timer.sv
module spi_half_timer #(
   parameter int MAX_SEL = 6
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic [2:0] sel,
   output logic       tick
);
   localparam int CW = MAX_SEL + 1;

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] lim;
   logic [2:0]    eff;

   assign eff  = (sel > 3'(MAX_SEL)) ? 3'(MAX_SEL) : sel;
   assign lim  = (CW'(1) << eff) - CW'(1);
   assign tick = run && (cnt_q == lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (!run || tick) cnt_q <= '0;
      else                   cnt_q <= cnt_q + CW'(1);
   end
endmodule

// File: rtl/spi_byte_bufs.sv
module spi_byte_bufs #(
   parameter int DEPTH = 64,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             tx_we,
   input  logic [IDX_W-1:0] tx_waddr,
   input  logic [7:0]       tx_wdata,
   input  logic [IDX_W-1:0] tx_raddr,
   output logic [7:0]       tx_rdata,
   input  logic             rx_we,
   input  logic [IDX_W-1:0] rx_waddr,
   input  logic [7:0]       rx_wdata,
   input  logic [IDX_W-1:0] rx_raddr,
   output logic [7:0]       rx_rdata
);
   logic [7:0] tx_mem [DEPTH];
   logic [7:0] rx_mem [DEPTH];

   always_ff @(posedge clk) begin
      if (tx_we) tx_mem[tx_waddr] <= tx_wdata;
      if (rx_we) rx_mem[rx_waddr] <= rx_wdata;
   end

   assign tx_rdata = tx_mem[tx_raddr];
   assign rx_rdata = rx_mem[rx_raddr];
endmodule

// File: rtl/spi_phase_seq.sv
module spi_phase_seq
   import spi_cmd_pkg::*;
#(
   parameter int DEPTH = 64,
   parameter int DEV_N = 4,
   localparam int CNT_W = $clog2(DEPTH + 1),
   localparam int IDX_W = $clog2(DEPTH),
   localparam int DEV_W = (DEV_N > 1) ? $clog2(DEV_N) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] cnt_in,
   input  logic [PRE_W-1:0] pre_in,
   input  xfer_type_e       type_in,
   input  logic [DEV_W-1:0] dev_in,
   input  logic             cpol,
   input  logic             cpha,
   input  logic             tick,
   input  logic [7:0]       tx_byte,
   input  logic             miso,
   input  logic             clr_done,
   output logic             busy,
   output logic             done,
   output logic             sclk,
   output logic             mosi,
   output logic [DEV_N-1:0] cs_n,
   output logic [IDX_W-1:0] tx_idx,
   output logic             rx_we,
   output logic [IDX_W-1:0] rx_idx,
   output logic [7:0]       rx_byte,
   output logic [CNT_W-1:0] rx_tail
);
   localparam int TOT_W = CNT_W + 1;

   logic             run_q, done_q;
   logic [3:0]       half_q;
   logic [TOT_W-1:0] bidx_q, total_q, total_new;
   logic [PRE_W-1:0] pre_q;
   xfer_type_e       type_q;
   logic [DEV_W-1:0] dev_q;
   logic [7:0]       sh_q;
   logic [CNT_W-1:0] tail_q;
   logic             in_pre, capture, last_byte, drive;

   assign total_new = TOT_W'(pre_in) + TOT_W'(cnt_in);
   assign in_pre    = bidx_q < TOT_W'(pre_q);
   assign capture   = !in_pre && (type_q == XT_FULL || type_q == XT_READ);
   assign last_byte = (bidx_q + TOT_W'(1)) == total_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q   <= 1'b0;
         done_q  <= 1'b0;
         half_q  <= '0;
         bidx_q  <= '0;
         total_q <= '0;
         pre_q   <= '0;
         type_q  <= XT_FULL;
         dev_q   <= '0;
         sh_q    <= '0;
         tail_q  <= '0;
      end else begin
         if (clr_done) done_q <= 1'b0;
         if (start) begin
            total_q <= total_new;
            pre_q   <= pre_in;
            type_q  <= type_in;
            dev_q   <= dev_in;
            bidx_q  <= '0;
            half_q  <= '0;
            tail_q  <= '0;
            if (total_new == '0) done_q <= 1'b1;
            else                 run_q  <= 1'b1;
         end else if (run_q && tick) begin
            half_q <= half_q + 4'd1;
            if (!half_q[0]) sh_q <= {sh_q[6:0], miso};
            if (half_q == 4'hF) begin
               bidx_q <= bidx_q + TOT_W'(1);
               if (capture) tail_q <= tail_q + CNT_W'(1);
               if (last_byte) begin
                  run_q  <= 1'b0;
                  done_q <= 1'b1;
               end
            end
         end
      end
   end

   assign drive   = run_q && (in_pre || type_q != XT_READ);
   assign mosi    = drive & tx_byte[3'd7 - half_q[3:1]];
   assign sclk    = cpol ^ (run_q & (half_q[0] ^ cpha));
   assign busy    = run_q;
   assign done    = done_q;
   assign rx_tail = tail_q;
   assign tx_idx  = bidx_q[IDX_W-1:0];
   assign rx_idx  = IDX_W'(bidx_q - TOT_W'(pre_q));
   assign rx_byte = sh_q;
   assign rx_we   = run_q && tick && (half_q == 4'hF) && capture;

   for (genvar g = 0; g < DEV_N; g++) begin : g_cs
      assign cs_n[g] = !(run_q && dev_q == DEV_W'(g));
   end
endmodule

// File: rtl/spi_cmd_master.sv
module spi_cmd_master
   import spi_cmd_pkg::*;
#(
   parameter int DEPTH   = 64,
   parameter int DEV_N   = 4,
   parameter int ADDR_W  = 8,
   parameter int MAX_SEL = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [15:0]      bus_wdata,
   output logic [15:0]      bus_rdata,
   output logic             spi_sclk,
   output logic             spi_mosi,
   input  logic             spi_miso,
   output logic [DEV_N-1:0] spi_cs_n,
   output logic             irq
);
   localparam int IDX_W = $clog2(DEPTH);
   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam int DEV_W = (DEV_N > 1) ? $clog2(DEV_N) : 1;

   if (DEPTH < 16 || DEPTH > 128) begin : g_bad_depth
      $error("DEPTH must lie in 16..128");
   end
   if (IDX_W > ADDR_W - 1) begin : g_bad_addr
      $error("ADDR_W too narrow for the buffer window");
   end
   if (DEV_W > 6) begin : g_bad_dev
      $error("DEV_N too large for the command word");
   end
   if (MAX_SEL < 1 || MAX_SEL > 7) begin : g_bad_sel
      $error("MAX_SEL must lie in 1..7");
   end

   logic             reg_hit, buf_hit;
   logic [2:0]       reg_idx;
   logic             start, clr_wr, busy, done, tick;
   logic [CNT_W-1:0] cnt_q, tail;
   xfer_type_e       type_q;
   logic             mask_q, cpol_q, cpha_q;
   logic [2:0]       sel_q;
   logic [IDX_W-1:0] tx_idx, rx_idx;
   logic [7:0]       tx_rd, rx_rd, rx_byte;
   logic             rx_we;
   logic             unused_wd;

   assign unused_wd = ^bus_wdata;
   assign reg_hit   = (bus_addr >> 3) == '0;
   assign buf_hit   = (bus_addr >> IDX_W) == (ADDR_W'(1) << (ADDR_W - 1 - IDX_W));
   assign reg_idx   = bus_addr[2:0];
   assign start     = bus_wr && reg_hit && reg_idx == A_CMD
                      && bus_wdata[1:0] == START_CODE && !busy;
   assign clr_wr    = bus_wr && reg_hit && reg_idx == A_STAT
                      && bus_wdata[7:0] == CLEAR_ALL;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         type_q <= XT_FULL;
         mask_q <= 1'b0;
         sel_q  <= '0;
         cpol_q <= 1'b0;
         cpha_q <= 1'b0;
      end else if (bus_wr && reg_hit) begin
         case (reg_idx)
            A_XFER: begin
               cnt_q  <= bus_wdata[CNT_W-1:0];
               type_q <= xfer_type_e'(bus_wdata[9:8]);
            end
            A_MASK: mask_q <= bus_wdata[0];
            A_CLK:  {cpha_q, cpol_q, sel_q} <= bus_wdata[4:0];
            A_RATE: sel_q <= bus_wdata[2:0];
            default: ;
         endcase
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (buf_hit) begin
         bus_rdata[7:0] = rx_rd;
      end else if (reg_hit) begin
         case (reg_idx)
            A_XFER: begin
               bus_rdata[CNT_W-1:0] = cnt_q;
               bus_rdata[9:8]       = type_q;
            end
            A_STAT: bus_rdata[1:0] = {busy, done};
            A_MASK: bus_rdata[0]   = mask_q;
            A_CLK:  bus_rdata[4:0] = {cpha_q, cpol_q, sel_q};
            A_TAIL: bus_rdata[CNT_W-1:0] = tail;
            default: ;
         endcase
      end
   end

   spi_half_timer #(.MAX_SEL(MAX_SEL)) u_timer (
      .clk(clk), .rst_n(rst_n), .run(busy), .sel(sel_q), .tick(tick)
   );

   spi_byte_bufs #(.DEPTH(DEPTH)) u_bufs (
      .clk(clk),
      .tx_we(bus_wr && buf_hit), .tx_waddr(bus_addr[IDX_W-1:0]),
      .tx_wdata(bus_wdata[7:0]), .tx_raddr(tx_idx), .tx_rdata(tx_rd),
      .rx_we(rx_we), .rx_waddr(rx_idx), .rx_wdata(rx_byte),
      .rx_raddr(bus_addr[IDX_W-1:0]), .rx_rdata(rx_rd)
   );

   spi_phase_seq #(.DEPTH(DEPTH), .DEV_N(DEV_N)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start),
      .cnt_in(cnt_q), .pre_in(bus_wdata[7:4]), .type_in(type_q),
      .dev_in(bus_wdata[8 +: DEV_W]), .cpol(cpol_q), .cpha(cpha_q),
      .tick(tick), .tx_byte(tx_rd), .miso(spi_miso), .clr_done(clr_wr),
      .busy(busy), .done(done), .sclk(spi_sclk), .mosi(spi_mosi),
      .cs_n(spi_cs_n), .tx_idx(tx_idx), .rx_we(rx_we), .rx_idx(rx_idx),
      .rx_byte(rx_byte), .rx_tail(tail)
   );

   assign irq = done & mask_q;
endmodule

// File: rtl/spi_cmd_master_chk.sv
module spi_cmd_master_chk #(
   parameter int DEV_N = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             busy,
   input logic             done,
   input logic             irq,
   input logic             mask_en,
   input logic [DEV_N-1:0] cs_n,
   input logic             sclk,
   input logic             cpol,
   input logic             clr_wr
);
   a_r6_single_select: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~cs_n));

   a_r6_idle_deselect: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (&cs_n));

   a_r9_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (sclk == cpol));

   a_r8_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (done && mask_en));

   a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !clr_wr) |=> done);
endmodule

bind spi_cmd_master spi_cmd_master_chk #(.DEV_N(DEV_N)) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .irq(irq),
   .mask_en(mask_q), .cs_n(spi_cs_n), .sclk(spi_sclk), .cpol(cpol_q),
   .clr_wr(clr_wr)
);

// File: tb/spi_cmd_master_test.sv
module spi_cmd_master_test;
   localparam int DEV_N = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        spi_sclk, spi_mosi;
   logic        spi_miso = 1'b0;
   logic [DEV_N-1:0] spi_cs_n;
   logic        irq;

   always #2 clk = ~clk;

   spi_cmd_master uut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sclk(spi_sclk),
      .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n), .irq(irq)
   );

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 0;

   // behavioural reference state
   bit m_run, m_done, m_mask, m_cpol, m_cpha, m_was_run;
   int m_sel, m_cnt, m_type, m_t, m_total, m_pre, m_ptype, m_dev, m_half;
   byte unsigned tx_img [128];
   byte unsigned slave_src [128];
   int c_b, c_h, c_ht;
   logic exp_sclk, exp_mosi, exp_irq;
   logic [DEV_N-1:0] exp_cs;

   task automatic check(input string req, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_run = 0; m_done = 0; m_mask = 0; m_cpol = 0; m_cpha = 0;
         m_sel = 0; m_cnt = 0; m_type = 0; m_t = 0; m_total = 0;
         m_pre = 0; m_ptype = 0; m_dev = 0; m_half = 1;
      end else begin
         m_was_run = m_run;
         if (m_run) begin
            m_t++;
            if (m_t == m_total * 16 * m_half) begin
               m_run = 0;
               m_done = 1;
            end
         end
         if (bus_wr && bus_addr < 8) begin
            case (bus_addr)
               0: begin m_cnt = int'(bus_wdata[6:0]); m_type = int'(bus_wdata[9:8]); end
               1: if (bus_wdata[1:0] == 2'b11 && !m_was_run) begin
                     m_pre = int'(bus_wdata[7:4]);
                     m_total = m_pre + m_cnt;
                     m_ptype = m_type;
                     m_dev = int'(bus_wdata[9:8]);
                     if (m_total == 0) m_done = 1;
                     else begin
                        m_run = 1;
                        m_t = 0;
                        m_half = 1 << ((m_sel > 6) ? 6 : m_sel);
                     end
                  end
               2: if (bus_wdata[7:0] == 8'hFF) m_done = 0;
               3: m_mask = bus_wdata[0];
               4: begin m_sel = int'(bus_wdata[2:0]); m_cpol = bus_wdata[3]; m_cpha = bus_wdata[4]; end
               6: m_sel = int'(bus_wdata[2:0]);
               default: ;
            endcase
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         c_b = 0; c_h = 0;
         if (m_run) begin
            c_ht = m_t / m_half;
            c_b = c_ht / 16;
            c_h = c_ht % 16;
         end
         exp_sclk = m_run ? (m_cpol ^ (m_cpha ? ((c_h % 2) == 0) : ((c_h % 2) == 1))) : m_cpol;
         exp_mosi = (m_run && (c_b < m_pre || m_ptype != 1)) ? tx_img[c_b][7 - c_h / 2] : 1'b0;
         for (int d = 0; d < DEV_N; d++) exp_cs[d] = !(m_run && m_dev == d);
         exp_irq = m_done && m_mask;
         check("R7/R9 sclk", int'(spi_sclk), int'(exp_sclk));
         check((m_run && c_b < m_pre) ? "R3 lead-in mosi" : "R4 main mosi",
               int'(spi_mosi), int'(exp_mosi));
         check("R6 chip selects", int'(spi_cs_n), int'(exp_cs));
         check("R8 irq", int'(irq), int'(exp_irq));
         spi_miso = m_run ? slave_src[c_b][7 - c_h / 2] : 1'b0;
      end
   end

   task automatic wr(input int a, input int d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = 8'(a); bus_wdata = 16'(d);
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input int a, output int v);
      @(negedge clk);
      bus_addr = 8'(a);
      #1 v = int'(bus_rdata);
   endtask

   task automatic wait_idle();
      @(negedge clk);
      while (m_run) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic run_cmd(input int pre, input int cnt, input int typ,
                          input int dev, input int seed, input string tag);
      int v;
      wr(2, 16'h00FF);
      for (int i = 0; i < pre + cnt; i++) begin
         tx_img[i] = 8'((i * 37 + seed * 11 + 5) & 255);
         slave_src[i] = 8'((i * 91 + seed * 29 + 3) & 255);
         wr(8'h80 + i, tx_img[i]);
      end
      wr(0, (typ << 8) | cnt);
      wr(1, (dev << 8) | (pre << 4) | 3);
      wait_idle();
      rd(5, v);
      check({tag, " R5 receive tail"}, v, (typ <= 1) ? cnt : 0);
      if (typ <= 1) begin
         for (int k = 0; k < cnt; k++) begin
            rd(8'h80 + k, v);
            check({tag, " R5 received byte"}, v, int'(slave_src[pre + k]));
         end
      end
      rd(2, v);
      check({tag, " R8 done after command"}, v, 1);
   endtask

   initial begin
      #(4 * 150000);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      int v;
      for (int i = 0; i < 128; i++) begin tx_img[i] = 0; slave_src[i] = 0; end
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 cs after reset", int'(spi_cs_n), 4'hF);
      check("R1 sclk after reset", int'(spi_sclk), 0);
      check("R1 mosi after reset", int'(spi_mosi), 0);
      check("R1 irq after reset", int'(irq), 0);
      rst_n = 1'b1;
      rd(2, v); check("R1 status after reset", v, 0);
      rd(5, v); check("R1 tail after reset", v, 0);

      // mode 0, fastest rate, full duplex, irq enabled
      wr(3, 1);
      wr(4, 5'b00000);
      run_cmd(0, 4, 0, 1, 1, "fd");

      // R3 lead-in then half-duplex read, mode 3, rate 2
      wr(4, 5'b11010);
      run_cmd(2, 3, 1, 2, 2, "R3 lead-in read");

      // half-duplex write, mode 1, rate 1, irq masked
      wr(3, 0);
      wr(4, 5'b10001);
      run_cmd(0, 5, 2, 3, 3, "hdw");

      // R8 clear pattern behaviour
      wr(3, 1);
      wr(2, 16'h00AA);
      rd(2, v); check("R8 non-pattern write keeps done", v, 1);
      wr(2, 16'h00FF);
      rd(2, v); check("R8 clear pattern clears done", v, 0);

      // R10 command while busy is ignored
      wr(4, 5'b01000);
      tx_img[0] = 8'hA5; tx_img[1] = 8'h3C;
      wr(8'h80, 8'hA5); wr(8'h81, 8'h3C);
      wr(0, (2 << 8) | 2);
      wr(1, (0 << 8) | 3);
      rd(2, v); check("R2/R10 busy during command", v, 2);
      wr(1, (3 << 8) | (1 << 4) | 3);
      wait_idle();
      rd(2, v); check("R10 ignored start left one completion", v, 1);

      // R11 zero-length command
      wr(2, 16'h00FF);
      wr(0, 0);
      wr(1, (2 << 8) | 3);
      rd(2, v); check("R11 zero length done, not busy", v, 1);
      check("R11 no select asserted", int'(spi_cs_n), 4'hF);

      // R12 rate-only write keeps polarity and phase
      wr(4, 5'b11010);
      wr(6, 5);
      rd(4, v); check("R12 clock config after rate write", v, 5'b11101);

      // R7 rate code 7 clamps to 6, mode 2 full duplex with lead-in absent
      wr(4, 5'b01111);
      run_cmd(0, 1, 0, 0, 4, "R7 clamp");

      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule